// File: doc/BRIEF.md
# Power Button and PMIC Enable Controller

This block watches a single mechanical power button and drives an active-low enable line toward an external power-management IC. The raw button is synchronised into the clock domain and then debounced. A press that has lasted through a configurable on-delay turns the platform on by pulling the enable line low. While the platform is on, a press held past a configurable timeout raises a set-power-off status flag, so software can decide how to react. Software can also request a power-off directly, which releases the enable line and sets both the set-power-off and emergency-off flags.

Every timer advances only on cycles where the `tick` input is high. A system would pulse `tick` once per millisecond. Each of the three timing fields is a 2-bit code that selects one of three parameterised tick limits, or zero. The block also shows the synchronised button level, and it latches a button-press flag whose interrupt output can be masked. All status flags are cleared by single-cycle clear pulses, which stand in for write-one-to-clear accesses.

Top module: `pwr_button_ctrl`

## Requirements
- R1: `btn_level` equals `btn_raw` delayed by a two-flop synchroniser, so it follows the input on the second rising clock edge after the input changes.
- R2: The debounced level takes the synchronised level only after the two have differed on L+1 consecutive ticks. Code 0 selects L=LIM_A, code 1 selects L=LIM_B, code 2 selects L=LIM_C and code 3 selects L=0. A shorter disagreement is discarded.
- R3: A rising debounced level sets `btn_irq_flag`. With `tick` high every cycle, the flag is visible 4+Ld edges after `btn_raw` rises. `btn_irq` is high only while the flag is set and `irq_mask` is low.
- R4: While the platform is off, a debounced press held for Lo+1 ticks (`cfg_on_time`, same coding as R2) drives `pmic_en_n` low. With `tick` always high, this happens 4+Ld+Lo edges after the press.
- R5: While the platform is on, a debounced press held for Lp+1 ticks (`cfg_press_time`, same coding) sets `set_off_flag` 5+Ld+Lo+Lp edges after the press. It fires once per press, leaves `emerg_off_flag` clear and leaves `pmic_en_n` low.
- R6: A `sw_turn_off` pulse while the platform is on raises `pmic_en_n` at the next edge and sets both `set_off_flag` and `emerg_off_flag`. While the platform is off, the pulse is ignored.
- R7: After a software power-off, the button must be seen released (debounced) before a new press can start the on-delay.
- R8: `clr_btn_irq`, `clr_set_off` and `clr_emerg_off` each clear their flag at the next edge. A set event in the same cycle wins over a clear.
- R9: While `tick` is low, the debounce, on-delay and long-press timers are all frozen. The synchroniser keeps running.
- R10: After reset, `pmic_en_n` is 1 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer advance enable |
| btn_raw | input | 1 | Raw button, 1 = pressed |
| cfg_debounce | input | 2 | Debounce time code |
| cfg_on_time | input | 2 | Power-on delay code |
| cfg_press_time | input | 2 | Long-press timeout code |
| irq_mask | input | 1 | 1 blocks `btn_irq` |
| sw_turn_off | input | 1 | Software power-off request pulse |
| clr_btn_irq | input | 1 | Clear pulse for button flag |
| clr_set_off | input | 1 | Clear pulse for set-power-off flag |
| clr_emerg_off | input | 1 | Clear pulse for emergency-off flag |
| btn_level | output | 1 | Synchronised button level |
| btn_irq_flag | output | 1 | Latched button-press flag |
| btn_irq | output | 1 | Masked button interrupt |
| set_off_flag | output | 1 | Set-power-off status |
| emerg_off_flag | output | 1 | Emergency-off status |
| pmic_en_n | output | 1 | Active-low PMIC enable |

## Verification
The hardest case to reach is a software power-off while the button is still held. Only there does the release-before-rearm rule matter. The stimulus first powers on with a press, keeps the button held, pulses `sw_turn_off`, and then holds the button for many timer lengths to show the enable line stays high. It then releases and presses again. The debounce boundary is reached with pulses exactly one tick shorter than, and exactly equal to, the required length. The set-versus-clear priority is reached by pulsing the clears in the same cycle as the power-off request. Latencies are swept over all 64 combinations of the three timing codes.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;

  // Code 0..2 pick a parameterised tick limit, code 3 means no wait.
  function automatic int unsigned sel_limit(input logic [1:0] code,
                                            input int unsigned lim_a,
                                            input int unsigned lim_b,
                                            input int unsigned lim_c);
    case (code)
      2'd0:    sel_limit = lim_a;
      2'd1:    sel_limit = lim_b;
      2'd2:    sel_limit = lim_c;
      default: sel_limit = 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pbc_debounce.sv
module pbc_debounce #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             btn_raw,
  input  logic [CNT_W-1:0] limit,
  output logic             btn_sync,
  output logic             btn_db
);

  logic             meta_q, sync_q;
  logic             db_q, db_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= btn_raw;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    db_d  = db_q;
    if (sync_q != db_q) begin
      if (tick) begin
        if (cnt_q >= limit) begin
          db_d  = sync_q;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      db_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      db_q  <= db_d;
    end
  end

  assign btn_sync = sync_q;
  assign btn_db   = db_q;

  // R2: the debounced level only moves on a tick with a disagreement
  p_db_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(db_q) |-> ($past(tick) && ($past(sync_q) != $past(db_q))));

  // R9: no tick, no progress
  p_db_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(db_q));

endmodule

// File: rtl/pbc_hold_timer.sv
module pbc_hold_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  assign fire = run & tick & ~done_q & (cnt_q >= limit);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q >= limit) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R5: one event per continuous hold
  p_single_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R9: counter holds while the tick is low
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pbc_power_fsm.sv
module pbc_power_fsm
  import pbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on_fire,
  input  logic sw_off,
  input  logic btn_db,
  output logic pwr_on,
  output logic armed,
  output logic off_evt
);

  pwr_state_e state_q, state_d;
  logic       hold_q, hold_d;

  assign off_evt = (state_q == PWR_ON) & sw_off;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    case (state_q)
      PWR_OFF: if (on_fire) state_d = PWR_ON;
      PWR_ON:  if (sw_off)  state_d = PWR_OFF;
      default: state_d = PWR_OFF;
    endcase
    if (off_evt) begin
      hold_d = 1'b1;
    end else if (!btn_db) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_OFF;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign pwr_on = (state_q == PWR_ON);
  assign armed  = ~hold_q;

  // R4: power comes on only from the on-delay timer
  p_on_from_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> $past(on_fire));

  // R6: power goes off only from a software request
  p_off_from_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> $past(sw_off));

  // R7: no on-delay progress while waiting for a release
  p_wait_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !pwr_on) |-> !on_fire);

endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl
  import pbc_pkg::*;
#(
  parameter int unsigned LIM_A = 50,
  parameter int unsigned LIM_B = 100,
  parameter int unsigned LIM_C = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_raw,
  input  logic [1:0] cfg_debounce,
  input  logic [1:0] cfg_on_time,
  input  logic [1:0] cfg_press_time,
  input  logic       irq_mask,
  input  logic       sw_turn_off,
  input  logic       clr_btn_irq,
  input  logic       clr_set_off,
  input  logic       clr_emerg_off,
  output logic       btn_level,
  output logic       btn_irq_flag,
  output logic       btn_irq,
  output logic       set_off_flag,
  output logic       emerg_off_flag,
  output logic       pmic_en_n
);

  localparam int unsigned LIM_MAX = max3(LIM_A, LIM_B, LIM_C);
  localparam int unsigned CNT_W   = (LIM_MAX < 2) ? 1 : $clog2(LIM_MAX + 1);

  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] lim_db, lim_on, lim_press;
  logic             btn_db, btn_db_q, press_rise;
  logic             pwr_on, armed, off_evt, on_fire, long_fire;
  logic             irq_q, irq_d, spo_q, spo_d, eo_q, eo_d;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign lim_db    = CNT_W'(sel_limit(cfg_debounce,   LIM_A, LIM_B, LIM_C));
  assign lim_on    = CNT_W'(sel_limit(cfg_on_time,    LIM_A, LIM_B, LIM_C));
  assign lim_press = CNT_W'(sel_limit(cfg_press_time, LIM_A, LIM_B, LIM_C));

  pbc_debounce #(.CNT_W(CNT_W)) u_debounce (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .tick     (tick),
    .btn_raw  (btn_raw),
    .limit    (lim_db),
    .btn_sync (btn_level),
    .btn_db   (btn_db)
  );

  pbc_hold_timer #(.CNT_W(CNT_W)) u_on_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .tick  (tick),
    .run   (~pwr_on & btn_db & armed),
    .limit (lim_on),
    .fire  (on_fire)
  );

  pbc_hold_timer #(.CNT_W(CNT_W)) u_press_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .tick  (tick),
    .run   (pwr_on & btn_db),
    .limit (lim_press),
    .fire  (long_fire)
  );

  pbc_power_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .on_fire (on_fire),
    .sw_off  (sw_turn_off),
    .btn_db  (btn_db),
    .pwr_on  (pwr_on),
    .armed   (armed),
    .off_evt (off_evt)
  );

  assign press_rise = btn_db & ~btn_db_q;

  // status flags: clear first, a same-cycle set overrides it
  always_comb begin
    irq_d = irq_q;
    spo_d = spo_q;
    eo_d  = eo_q;
    if (clr_btn_irq)   irq_d = 1'b0;
    if (clr_set_off)   spo_d = 1'b0;
    if (clr_emerg_off) eo_d  = 1'b0;
    if (press_rise)           irq_d = 1'b1;
    if (long_fire || off_evt) spo_d = 1'b1;
    if (off_evt)              eo_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      btn_db_q <= 1'b0;
      irq_q    <= 1'b0;
      spo_q    <= 1'b0;
      eo_q     <= 1'b0;
    end else begin
      btn_db_q <= btn_db;
      irq_q    <= irq_d;
      spo_q    <= spo_d;
      eo_q     <= eo_d;
    end
  end

  assign btn_irq_flag   = irq_q;
  assign btn_irq        = irq_q & ~irq_mask;
  assign set_off_flag   = spo_q;
  assign emerg_off_flag = eo_q;
  assign pmic_en_n      = ~pwr_on;

  // R3: the press flag rises only after a debounced press edge
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(irq_q) |-> $past(press_rise));

  // R5: set-power-off rises only from a long press or software request
  p_spo_cause_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(spo_q) |-> $past(long_fire || off_evt));

  // R6: emergency-off rises only from a software request while on
  p_eo_cause_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(eo_q) |-> $past(off_evt));

  // R8: a flag cannot fall unless its clear was pulsed
  p_clear_only_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(spo_q) |-> $past(clr_set_off));

endmodule

// File: tb/pwr_button_ctrl_bench.sv
module pwr_button_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LA = 3;
  localparam int LB = 5;
  localparam int LC = 9;

  logic clk = 1'b0;
  logic rst_n, tick, btn_raw, irq_mask, sw_turn_off;
  logic clr_btn_irq, clr_set_off, clr_emerg_off;
  logic [1:0] cfg_debounce, cfg_on_time, cfg_press_time;
  logic btn_level, btn_irq_flag, btn_irq, set_off_flag, emerg_off_flag, pmic_en_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_button_ctrl #(.LIM_A(LA), .LIM_B(LB), .LIM_C(LC)) u_pwr_button_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_raw(btn_raw),
    .cfg_debounce(cfg_debounce), .cfg_on_time(cfg_on_time),
    .cfg_press_time(cfg_press_time), .irq_mask(irq_mask),
    .sw_turn_off(sw_turn_off), .clr_btn_irq(clr_btn_irq),
    .clr_set_off(clr_set_off), .clr_emerg_off(clr_emerg_off),
    .btn_level(btn_level), .btn_irq_flag(btn_irq_flag), .btn_irq(btn_irq),
    .set_off_flag(set_off_flag), .emerg_off_flag(emerg_off_flag),
    .pmic_en_n(pmic_en_n)
  );

  function automatic int lim(input int code);
    case (code)
      0: lim = LA;
      1: lim = LB;
      2: lim = LC;
      default: lim = 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b1; btn_raw = 1'b0; irq_mask = 1'b0;
    sw_turn_off = 1'b0; clr_btn_irq = 1'b0; clr_set_off = 1'b0; clr_emerg_off = 1'b0;
    cfg_debounce = 2'd3; cfg_on_time = 2'd3; cfg_press_time = 2'd3;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
  endtask

  // button held for k cycles, then released; returns whether a press flag appeared
  task automatic pulse_btn(input int k, output int seen);
    seen = 0;
    btn_raw = 1'b1;
    cycles(k);
    btn_raw = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (btn_irq_flag) seen = 1;
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      report();
    end
  end

  initial begin
    int seen;
    do_reset();
    // R10 reset state
    chk("R10 pmic_en_n", pmic_en_n, 1);
    chk("R10 irq flag", btn_irq_flag, 0);
    chk("R10 set_off", set_off_flag, 0);
    chk("R10 emerg_off", emerg_off_flag, 0);

    // R1 synchroniser latency
    btn_raw = 1'b1;
    @(posedge clk); #1; chk("R1 level after 1 edge", btn_level, 0);
    @(posedge clk); #1; chk("R1 level after 2 edges", btn_level, 1);
    @(negedge clk); btn_raw = 1'b0;

    // R2 R3 R4 R5 exhaustive timing sweep
    for (int d = 0; d < 4; d++) begin
      for (int o = 0; o < 4; o++) begin
        for (int p = 0; p < 4; p++) begin
          int t_irq, t_on, t_spo;
          do_reset();
          cfg_debounce = d[1:0]; cfg_on_time = o[1:0]; cfg_press_time = p[1:0];
          t_irq = 0; t_on = 0; t_spo = 0;
          @(negedge clk);
          btn_raw = 1'b1;
          for (int n = 1; n <= 60; n++) begin
            @(posedge clk); #1;
            if (btn_irq_flag && t_irq == 0) t_irq = n;
            if (!pmic_en_n && t_on == 0) t_on = n;
            if (set_off_flag && t_spo == 0) t_spo = n;
          end
          chk("R3 R2 irq latency", t_irq, 4 + lim(d));
          chk("R4 power-on latency", t_on, 4 + lim(d) + lim(o));
          chk("R5 long-press latency", t_spo, 5 + lim(d) + lim(o) + lim(p));
          chk("R5 emerg_off stays clear", emerg_off_flag, 0);
          chk("R5 power stays on", pmic_en_n, 0);
          @(negedge clk); btn_raw = 1'b0;
        end
      end
    end

    // R2 debounce boundary: code 1 needs LB+1 ticks of disagreement
    do_reset();
    cfg_debounce = 2'd1; cfg_on_time = 2'd2;
    pulse_btn(LB, seen);
    chk("R2 short pulse rejected", seen, 0);
    pulse_btn(LB + 1, seen);
    chk("R2 exact pulse accepted", seen, 1);

    // R3 mask and R8 clear of press flag
    irq_mask = 1'b0; @(posedge clk); #1;
    chk("R3 irq unmasked", btn_irq, 1);
    @(negedge clk); irq_mask = 1'b1; @(posedge clk); #1;
    chk("R3 irq masked", btn_irq, 0);
    chk("R3 flag kept under mask", btn_irq_flag, 1);
    @(negedge clk); clr_btn_irq = 1'b1; @(negedge clk); clr_btn_irq = 1'b0;
    chk("R8 press flag cleared", btn_irq_flag, 0);

    // R9 tick held low freezes everything but the synchroniser
    do_reset();
    cfg_debounce = 2'd3; cfg_on_time = 2'd3;
    tick = 1'b0; btn_raw = 1'b1;
    cycles(40);
    chk("R9 level still follows", btn_level, 1);
    chk("R9 no debounced press", btn_irq_flag, 0);
    chk("R9 power stays off", pmic_en_n, 1);
    tick = 1'b1;
    cycles(4);
    chk("R9 resumes with tick", pmic_en_n, 0);
    btn_raw = 1'b0; cycles(6);

    // R6 software off while on, with clears in the same cycle (R8)
    do_reset();
    cfg_debounce = 2'd3; cfg_on_time = 2'd3; cfg_press_time = 2'd2;
    btn_raw = 1'b1; cycles(6); btn_raw = 1'b0; cycles(6);
    chk("R6 precondition power on", pmic_en_n, 0);
    chk("R6 no long press yet", set_off_flag, 0);
    sw_turn_off = 1'b1; clr_set_off = 1'b1; clr_emerg_off = 1'b1;
    @(posedge clk); #1;
    chk("R6 power off next edge", pmic_en_n, 1);
    chk("R8 set wins over clear spo", set_off_flag, 1);
    chk("R8 set wins over clear eo", emerg_off_flag, 1);
    @(negedge clk); sw_turn_off = 1'b0; clr_emerg_off = 1'b0;
    @(negedge clk); clr_set_off = 1'b0;
    chk("R8 spo cleared", set_off_flag, 0);
    chk("R8 eo untouched", emerg_off_flag, 1);
    @(negedge clk); clr_emerg_off = 1'b1; @(negedge clk); clr_emerg_off = 1'b0;
    chk("R8 eo cleared", emerg_off_flag, 0);
    sw_turn_off = 1'b1; @(negedge clk); sw_turn_off = 1'b0; @(negedge clk);
    chk("R6 ignored when off spo", set_off_flag, 0);
    chk("R6 ignored when off eo", emerg_off_flag, 0);
    chk("R6 ignored when off pmic", pmic_en_n, 1);

    // R7 software off while the button is still held
    btn_raw = 1'b1; cycles(6);
    chk("R7 precondition on", pmic_en_n, 0);
    sw_turn_off = 1'b1; @(negedge clk); sw_turn_off = 1'b0;
    cycles(40);
    chk("R7 stays off while held", pmic_en_n, 1);
    btn_raw = 1'b0; cycles(8);
    chk("R7 still off after release", pmic_en_n, 1);
    btn_raw = 1'b1;
    cycles(4);
    chk("R7 rearmed press powers on", pmic_en_n, 0);
    btn_raw = 1'b0; cycles(4);

    done = 1'b1;
    report();
  end

endmodule